// File: doc/BRIEF.md
# Privileged Register Access Router

This block sits between the instruction decode of a processor core and its system-register file. For each system-register read or write request it decides where the access goes. The request carries the five encoding fields, a read/write flag, the current privilege level (0 to 3) and four virtualization control bits. The router answers with exactly one outcome: access the level-1 copy of the saved-status register, access the level-2 copy, redirect the access to a fixed offset in memory, trap to level 2 with a syndrome class, or raise an undefined-instruction exception.

One physical saved-status register is reachable through three aliases: a native alias, a cross-level alias and a level-2 alias. The virtualization controls decide between a trap, a redirect to memory and a swapped target. A request whose encoding matches none of the three aliases is flagged as a non-match, so other decoders can claim it. The outcome is registered and appears one clock after the request. The register storage and the memory access itself are handled elsewhere.

The control inputs are: `ctl_nest` (nested virtualization enable), `ctl_nest_alt` (alternate nesting mode), `ctl_nest_mem` (nesting through memory), `ctl_host_ext` (level-2 host extension), `lvl2_on` (level 2 enabled) and `lvl2_narrow` (level 2 runs in 32-bit state).

Top module: `sysreg_route`

## Requirements
- R1: An encoding matches only when group=3, major=4, minor=0 and sub=0. Within that, opa=0 selects the native alias, opa=5 the cross-level alias and opa=4 the level-2 alias. Any other encoding yields the outcome vector 6'b100000 (non-match only).
- R2: A matching request at privilege 0 through any alias yields undefined (bit 4).
- R3: Native alias at privilege 1 with `lvl2_on`=1, `ctl_nest_mem`=0 and `ctl_nest_alt`=1 yields a trap (bit 3) with class 0x18.
- R4: Native alias at privilege 1, when R3 does not apply: it yields a redirect (bit 2) to offset 0x160 if `lvl2_on`=1, `lvl2_narrow`=0 and all three nesting bits are 1. Otherwise it yields a level-1 register access (bit 0).
- R5: Native alias at privilege 2 yields a level-2 register access (bit 1) when `ctl_host_ext`=1, and a level-1 access otherwise. At privilege 3 it always yields a level-1 access.
- R6: Cross-level alias at privilege 1 yields a redirect to 0x160 when `lvl2_on`=1 and {mem,alt,nest}=101. Otherwise it yields a trap with class 0x18 when `lvl2_on`=1 and `ctl_nest`=1. Otherwise it yields undefined.
- R7: Cross-level alias at privilege 2 or 3 yields a level-1 access when `lvl2_on`=1 and `ctl_host_ext`=1, and undefined otherwise.
- R8: Level-2 alias at privilege 1 yields a level-1 access when `lvl2_on`=1, `ctl_nest_mem`=1 and `ctl_nest`=1. Otherwise it yields a trap with class 0x18 when `lvl2_on`=1 and `ctl_nest`=1. Otherwise it yields undefined. At privilege 2 or 3 it yields a level-2 access.
- R9: The outcome vector is one-hot while `res_valid`=1. Its bits are: 0 level-1 register, 1 level-2 register, 2 redirect, 3 trap, 4 undefined, 5 non-match. `res_offset` is 0x160 only with a redirect and 0 otherwise. `res_class` is 0x18 only with a trap and 0 otherwise. `res_tgt_high` equals bit 1.
- R10: A request sampled on a rising edge produces its result, with `res_valid`=1 and `res_write` echoing `req_write`, right after that edge. Back-to-back requests give back-to-back results. A cycle without a request gives `res_valid`=0 with the vector, offset and class all zero.
- R11: After reset `res_valid` is 0 and the outcome vector, offset and class are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_grp | input | 2 | Encoding group field |
| req_opa | input | 3 | Encoding first opcode field (alias select) |
| req_major | input | 4 | Encoding major register field |
| req_minor | input | 4 | Encoding minor register field |
| req_opb | input | 3 | Encoding second opcode field |
| req_priv | input | 2 | Current privilege level |
| ctl_nest | input | 1 | Nested virtualization enable |
| ctl_nest_alt | input | 1 | Alternate nesting mode |
| ctl_nest_mem | input | 1 | Nesting through memory |
| ctl_host_ext | input | 1 | Level-2 host extension |
| lvl2_on | input | 1 | Level 2 enabled |
| lvl2_narrow | input | 1 | Level 2 uses 32-bit state |
| res_valid | output | 1 | Result present |
| res_write | output | 1 | Echoed read/write flag |
| res_kind | output | 6 | One-hot outcome vector |
| res_tgt_high | output | 1 | Register target is the level-2 copy |
| res_offset | output | 12 | Redirect memory offset |
| res_class | output | 6 | Trap syndrome class |

## Verification
Every result is due exactly one rising edge after the request. Nothing else in the block has latency. The bench drives each request on a falling edge, lets one rising edge pass, and samples all outputs on the next falling edge. At that same falling edge it either drives the next request or drops `req_valid`, and it checks the idle outputs one edge later. The back-to-back test checks the first result before it drives the second request. This pins both results to their own edges.

// File: rtl/sysreg_route_pkg.sv
package sysreg_route_pkg;
  localparam int KIND_W   = 6;
  localparam int K_LOW    = 0;
  localparam int K_HIGH   = 1;
  localparam int K_REDIR  = 2;
  localparam int K_TRAP   = 3;
  localparam int K_UNDEF  = 4;
  localparam int K_NOHIT  = 5;

  typedef logic [KIND_W-1:0] kind_t;

  typedef enum logic [1:0] {
    AL_NATIVE = 2'd0,
    AL_CROSS  = 2'd1,
    AL_HIGH   = 2'd2,
    AL_NONE   = 2'd3
  } alias_e;

  typedef struct packed {
    logic nest;
    logic nest_alt;
    logic nest_mem;
    logic host_ext;
    logic l2_on;
    logic l2_narrow;
  } virt_ctl_t;
endpackage

// File: rtl/sr_alias_decode.sv
module sr_alias_decode #(
  parameter int GRP_W   = 2,
  parameter int OPA_W   = 3,
  parameter int CR_W    = 4,
  parameter int OPB_W   = 3,
  parameter logic [GRP_W-1:0] GRP_VAL   = 2'd3,
  parameter logic [CR_W-1:0]  MAJOR_VAL = 4'd4,
  parameter logic [CR_W-1:0]  MINOR_VAL = 4'd0,
  parameter logic [OPB_W-1:0] OPB_VAL   = 3'd0,
  parameter logic [OPA_W-1:0] OPA_NATIVE = 3'd0,
  parameter logic [OPA_W-1:0] OPA_CROSS  = 3'd5,
  parameter logic [OPA_W-1:0] OPA_HIGH   = 3'd4
) (
  input  logic [GRP_W-1:0] grp,
  input  logic [OPA_W-1:0] opa,
  input  logic [CR_W-1:0]  major,
  input  logic [CR_W-1:0]  minor,
  input  logic [OPB_W-1:0] opb,
  output sysreg_route_pkg::alias_e sel
);
  import sysreg_route_pkg::*;

  localparam int NUM_ALIAS = 3;
  localparam logic [OPA_W-1:0] OPA_TAB [NUM_ALIAS] = '{OPA_NATIVE, OPA_CROSS, OPA_HIGH};

  logic                 base_hit;
  logic [NUM_ALIAS-1:0] hit;

  assign base_hit = (grp == GRP_VAL) && (major == MAJOR_VAL) &&
                    (minor == MINOR_VAL) && (opb == OPB_VAL);

  for (genvar gi = 0; gi < NUM_ALIAS; gi++) begin : g_alias
    assign hit[gi] = base_hit && (opa == OPA_TAB[gi]);
  end

  always_comb begin
    sel = AL_NONE;
    if (hit[0])      sel = AL_NATIVE;
    else if (hit[1]) sel = AL_CROSS;
    else if (hit[2]) sel = AL_HIGH;
  end
endmodule

// File: rtl/sr_access_policy.sv
module sr_access_policy (
  input  sysreg_route_pkg::alias_e    sel,
  input  logic [1:0]                  priv,
  input  sysreg_route_pkg::virt_ctl_t ctl,
  output sysreg_route_pkg::kind_t     kind
);
  import sysreg_route_pkg::*;

  logic all_nest;
  logic mem_only;

  assign all_nest = ctl.nest_mem && ctl.nest_alt && ctl.nest;
  assign mem_only = ctl.nest_mem && !ctl.nest_alt && ctl.nest;

  always_comb begin
    kind = '0;
    if (sel == AL_NONE) begin
      kind[K_NOHIT] = 1'b1;
    end else if (priv == 2'd0) begin
      kind[K_UNDEF] = 1'b1;
    end else begin
      case (sel)
        AL_NATIVE: begin
          if (priv == 2'd1) begin
            if (ctl.l2_on && !ctl.nest_mem && ctl.nest_alt)
              kind[K_TRAP] = 1'b1;
            else if (ctl.l2_on && !ctl.l2_narrow && all_nest)
              kind[K_REDIR] = 1'b1;
            else
              kind[K_LOW] = 1'b1;
          end else if (priv == 2'd2 && ctl.host_ext) begin
            kind[K_HIGH] = 1'b1;
          end else begin
            kind[K_LOW] = 1'b1;
          end
        end
        AL_CROSS: begin
          if (priv == 2'd1) begin
            if (ctl.l2_on && mem_only)
              kind[K_REDIR] = 1'b1;
            else if (ctl.l2_on && ctl.nest)
              kind[K_TRAP] = 1'b1;
            else
              kind[K_UNDEF] = 1'b1;
          end else if (ctl.l2_on && ctl.host_ext) begin
            kind[K_LOW] = 1'b1;
          end else begin
            kind[K_UNDEF] = 1'b1;
          end
        end
        AL_HIGH: begin
          if (priv == 2'd1) begin
            if (ctl.l2_on && ctl.nest_mem && ctl.nest)
              kind[K_LOW] = 1'b1;
            else if (ctl.l2_on && ctl.nest)
              kind[K_TRAP] = 1'b1;
            else
              kind[K_UNDEF] = 1'b1;
          end else begin
            kind[K_HIGH] = 1'b1;
          end
        end
        default: kind[K_NOHIT] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sr_result_reg.sv
module sr_result_reg #(
  parameter int OFS_W   = 12,
  parameter int CLASS_W = 6,
  parameter logic [OFS_W-1:0]   REDIR_OFS  = 12'h160,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_write,
  input  sysreg_route_pkg::kind_t in_kind,
  output logic                    out_valid,
  output logic                    out_write,
  output sysreg_route_pkg::kind_t out_kind,
  output logic                    out_high,
  output logic [OFS_W-1:0]        out_offset,
  output logic [CLASS_W-1:0]      out_class
);
  import sysreg_route_pkg::*;

  logic               valid_d;
  logic               write_d;
  kind_t              kind_d;
  logic [OFS_W-1:0]   ofs_d;
  logic [CLASS_W-1:0] cls_d;
  logic               upd_en;

  assign upd_en = in_valid || out_valid;

  always_comb begin
    valid_d = in_valid;
    write_d = in_valid && in_write;
    kind_d  = in_valid ? in_kind : '0;
    ofs_d   = (in_valid && in_kind[K_REDIR]) ? REDIR_OFS : '0;
    cls_d   = (in_valid && in_kind[K_TRAP]) ? TRAP_CLASS : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_write  <= 1'b0;
      out_kind   <= '0;
      out_offset <= '0;
      out_class  <= '0;
    end else if (upd_en) begin
      out_valid  <= valid_d;
      out_write  <= write_d;
      out_kind   <= kind_d;
      out_offset <= ofs_d;
      out_class  <= cls_d;
    end
  end

  assign out_high = out_kind[K_HIGH];
endmodule

// File: rtl/sysreg_route.sv
module sysreg_route #(
  parameter int OFS_W   = 12,
  parameter int CLASS_W = 6,
  parameter logic [OFS_W-1:0]   REDIR_OFS  = 12'h160,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_grp,
  input  logic [2:0]         req_opa,
  input  logic [3:0]         req_major,
  input  logic [3:0]         req_minor,
  input  logic [2:0]         req_opb,
  input  logic [1:0]         req_priv,
  input  logic               ctl_nest,
  input  logic               ctl_nest_alt,
  input  logic               ctl_nest_mem,
  input  logic               ctl_host_ext,
  input  logic               lvl2_on,
  input  logic               lvl2_narrow,
  output logic               res_valid,
  output logic               res_write,
  output logic [5:0]         res_kind,
  output logic               res_tgt_high,
  output logic [OFS_W-1:0]   res_offset,
  output logic [CLASS_W-1:0] res_class
);
  import sysreg_route_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  alias_e     sel;
  virt_ctl_t  ctl;
  kind_t      kind_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign ctl = '{nest: ctl_nest, nest_alt: ctl_nest_alt, nest_mem: ctl_nest_mem,
                 host_ext: ctl_host_ext, l2_on: lvl2_on, l2_narrow: lvl2_narrow};

  sr_alias_decode u_decode (
    .grp   (req_grp),
    .opa   (req_opa),
    .major (req_major),
    .minor (req_minor),
    .opb   (req_opb),
    .sel   (sel)
  );

  sr_access_policy u_policy (
    .sel  (sel),
    .priv (req_priv),
    .ctl  (ctl),
    .kind (kind_c)
  );

  sr_result_reg #(
    .OFS_W(OFS_W), .CLASS_W(CLASS_W), .REDIR_OFS(REDIR_OFS), .TRAP_CLASS(TRAP_CLASS)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (req_valid),
    .in_write   (req_write),
    .in_kind    (kind_c),
    .out_valid  (res_valid),
    .out_write  (res_write),
    .out_kind   (res_kind),
    .out_high   (res_tgt_high),
    .out_offset (res_offset),
    .out_class  (res_class)
  );
endmodule

// File: rtl/sysreg_route_chk.sv
module sysreg_route_chk #(
  parameter int OFS_W   = 12,
  parameter int CLASS_W = 6,
  parameter logic [OFS_W-1:0]   REDIR_OFS  = 12'h160,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_grp,
  input logic [2:0]         req_opa,
  input logic [3:0]         req_major,
  input logic [3:0]         req_minor,
  input logic [2:0]         req_opb,
  input logic [1:0]         req_priv,
  input logic               res_valid,
  input logic [5:0]         res_kind,
  input logic               res_tgt_high,
  input logic [OFS_W-1:0]   res_offset,
  input logic [CLASS_W-1:0] res_class
);
  logic enc_ok;
  assign enc_ok = (req_grp == 2'd3) && (req_major == 4'd4) &&
                  (req_minor == 4'd0) && (req_opb == 3'd0);

  a_r9_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones(res_kind) == 1);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_kind == '0 && res_offset == '0 && res_class == '0));
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r9_offset: assert property (@(posedge clk) disable iff (!rst_n)
    res_offset == (res_kind[2] ? REDIR_OFS : '0));
  a_r9_class: assert property (@(posedge clk) disable iff (!rst_n)
    res_class == (res_kind[3] ? TRAP_CLASS : '0));
  a_r9_target: assert property (@(posedge clk) disable iff (!rst_n)
    res_tgt_high == res_kind[1]);
  a_r1_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !enc_ok) |=> res_kind == 6'b100000);
  a_r2_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enc_ok && req_priv == 2'd0 &&
     (req_opa == 3'd0 || req_opa == 3'd4 || req_opa == 3'd5)) |=> res_kind == 6'b010000);
  a_r8_high_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enc_ok && req_opa == 3'd4 && req_priv[1]) |=> res_kind == 6'b000010);
endmodule

bind sysreg_route sysreg_route_chk #(
  .OFS_W(OFS_W), .CLASS_W(CLASS_W), .REDIR_OFS(REDIR_OFS), .TRAP_CLASS(TRAP_CLASS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grp(req_grp),
  .req_opa(req_opa), .req_major(req_major), .req_minor(req_minor),
  .req_opb(req_opb), .req_priv(req_priv), .res_valid(res_valid),
  .res_kind(res_kind), .res_tgt_high(res_tgt_high), .res_offset(res_offset),
  .res_class(res_class)
);

// File: tb/sysreg_route_bench.sv
`timescale 1ns/1ps
module sysreg_route_bench;
  localparam logic [5:0] E_LOW = 6'b000001, E_HIGH = 6'b000010, E_RD = 6'b000100,
                         E_TR = 6'b001000, E_UD = 6'b010000, E_NO = 6'b100000;

  logic clk, rst_n;
  logic req_valid, req_write;
  logic [1:0] req_grp, req_priv;
  logic [2:0] req_opa, req_opb;
  logic [3:0] req_major, req_minor;
  logic ctl_nest, ctl_nest_alt, ctl_nest_mem, ctl_host_ext, lvl2_on, lvl2_narrow;
  logic res_valid, res_write, res_tgt_high;
  logic [5:0] res_kind;
  logic [11:0] res_offset;
  logic [5:0] res_class;
  int total, bad;

  sysreg_route u_sysreg_route (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] model(input logic [2:0] opa, input logic [1:0] pv,
      input logic n, input logic a, input logic m, input logic h,
      input logic on, input logic nar);
    if (opa != 3'd0 && opa != 3'd4 && opa != 3'd5) return E_NO;
    if (pv == 2'd0) return E_UD;
    if (opa == 3'd0) begin
      if (pv == 2'd1) begin
        if (on && !m && a) return E_TR;
        if (on && !nar && m && a && n) return E_RD;
        return E_LOW;
      end
      return (pv == 2'd2 && h) ? E_HIGH : E_LOW;
    end
    if (opa == 3'd5) begin
      if (pv == 2'd1) begin
        if (on && m && !a && n) return E_RD;
        if (on && n) return E_TR;
        return E_UD;
      end
      return (on && h) ? E_LOW : E_UD;
    end
    if (pv == 2'd1) begin
      if (on && m && n) return E_LOW;
      if (on && n) return E_TR;
      return E_UD;
    end
    return E_HIGH;
  endfunction

  task automatic drive(input logic wr, input logic [1:0] g, input logic [2:0] oa,
      input logic [3:0] mj, input logic [3:0] mn, input logic [2:0] ob,
      input logic [1:0] pv, input logic [5:0] c);
    req_valid = 1'b1; req_write = wr; req_grp = g; req_opa = oa; req_major = mj;
    req_minor = mn; req_opb = ob; req_priv = pv;
    {ctl_nest, ctl_nest_alt, ctl_nest_mem, ctl_host_ext, lvl2_on, lvl2_narrow} = c;
  endtask

  task automatic check_res(input string tag, input logic wr, input logic [5:0] ek);
    chk({tag, " valid"}, res_valid, 1);
    chk({tag, " write R10"}, res_write, wr);
    chk({tag, " kind"}, res_kind, ek);
    chk({tag, " offset R9"}, res_offset, ek[2] ? 12'h160 : 12'h0);
    chk({tag, " class R9"}, res_class, ek[3] ? 6'h18 : 6'h0);
    chk({tag, " target R9"}, res_tgt_high, ek[1]);
  endtask

  // one request on the canonical encoding with the given alias
  task automatic one(input string tag, input logic [2:0] oa, input logic [1:0] pv,
      input logic [5:0] c, input logic [5:0] ek);
    drive(1'b0, 2'd3, oa, 4'd4, 4'd0, 3'd0, pv, c);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check_res(tag, 1'b0, ek);
  endtask

  task automatic t_idle(input string tag);
    @(posedge clk); @(negedge clk);
    chk({tag, " idle valid"}, res_valid, 0);
    chk({tag, " idle kind"}, res_kind, 0);
    chk({tag, " idle offset"}, res_offset, 0);
    chk({tag, " idle class"}, res_class, 0);
  endtask

  task automatic t_reset();
    chk("R11 reset valid", res_valid, 0);
    chk("R11 reset kind", res_kind, 0);
    chk("R11 reset offset", res_offset, 0);
    chk("R11 reset class", res_class, 0);
  endtask

  task automatic t_nomatch();
    drive(1'b1, 2'd2, 3'd0, 4'd4, 4'd0, 3'd0, 2'd1, 6'b0); @(posedge clk); @(negedge clk);
    check_res("R1 grp", 1'b1, E_NO);
    drive(1'b0, 2'd3, 3'd0, 4'd5, 4'd0, 3'd0, 2'd1, 6'b0); @(posedge clk); @(negedge clk);
    check_res("R1 major", 1'b0, E_NO);
    drive(1'b0, 2'd3, 3'd0, 4'd4, 4'd1, 3'd0, 2'd0, 6'b0); @(posedge clk); @(negedge clk);
    check_res("R1 minor priv0", 1'b0, E_NO);
    drive(1'b0, 2'd3, 3'd4, 4'd4, 4'd0, 3'd1, 2'd3, 6'b0); @(posedge clk); @(negedge clk);
    check_res("R1 opb", 1'b0, E_NO);
    req_valid = 1'b0;
    one("R1 opa1", 3'd1, 2'd1, 6'b0, E_NO);
    one("R1 opa7", 3'd7, 2'd2, 6'b0, E_NO);
  endtask

  task automatic t_user();
    one("R2 native", 3'd0, 2'd0, 6'b000010, E_UD);
    one("R2 cross", 3'd5, 2'd0, 6'b100110, E_UD);
    one("R2 high", 3'd4, 2'd0, 6'b101010, E_UD);
  endtask

  // control order: {nest, nest_alt, nest_mem, host_ext, lvl2_on, lvl2_narrow}
  task automatic t_native_l1();
    one("R3 trap", 3'd0, 2'd1, 6'b010010, E_TR);
    one("R3 trap nest", 3'd0, 2'd1, 6'b110011, E_TR);
    one("R3 l2 off", 3'd0, 2'd1, 6'b010000, E_LOW);
    one("R4 redirect", 3'd0, 2'd1, 6'b111010, E_RD);
    one("R4 narrow", 3'd0, 2'd1, 6'b111011, E_LOW);
    one("R4 plain", 3'd0, 2'd1, 6'b000000, E_LOW);
  endtask

  task automatic t_native_hi();
    one("R5 l2 host", 3'd0, 2'd2, 6'b000100, E_HIGH);
    one("R5 l2 nohost", 3'd0, 2'd2, 6'b111010, E_LOW);
    one("R5 l3 host", 3'd0, 2'd3, 6'b000110, E_LOW);
  endtask

  task automatic t_cross_l1();
    one("R6 redirect", 3'd5, 2'd1, 6'b101010, E_RD);
    one("R6 trap", 3'd5, 2'd1, 6'b100010, E_TR);
    one("R6 trap all", 3'd5, 2'd1, 6'b111010, E_TR);
    one("R6 undef", 3'd5, 2'd1, 6'b011010, E_UD);
    one("R6 l2 off", 3'd5, 2'd1, 6'b101000, E_UD);
  endtask

  task automatic t_cross_hi();
    one("R7 l2 ok", 3'd5, 2'd2, 6'b000110, E_LOW);
    one("R7 l3 ok", 3'd5, 2'd3, 6'b000110, E_LOW);
    one("R7 nohost", 3'd5, 2'd2, 6'b000010, E_UD);
    one("R7 l2 off", 3'd5, 2'd3, 6'b000100, E_UD);
  endtask

  task automatic t_high_alias();
    one("R8 swap", 3'd4, 2'd1, 6'b101010, E_LOW);
    one("R8 trap", 3'd4, 2'd1, 6'b110010, E_TR);
    one("R8 undef", 3'd4, 2'd1, 6'b001010, E_UD);
    one("R8 l2 off", 3'd4, 2'd1, 6'b101000, E_UD);
    one("R8 l2", 3'd4, 2'd2, 6'b000000, E_HIGH);
    one("R8 l3", 3'd4, 2'd3, 6'b111111, E_HIGH);
  endtask

  task automatic t_timing();
    drive(1'b1, 2'd3, 3'd0, 4'd4, 4'd0, 3'd0, 2'd1, 6'b111010);
    @(posedge clk); @(negedge clk);
    check_res("R10 first", 1'b1, E_RD);
    drive(1'b0, 2'd3, 3'd4, 4'd4, 4'd0, 3'd0, 2'd2, 6'b0);
    @(posedge clk); @(negedge clk);
    check_res("R10 second", 1'b0, E_HIGH);
    req_valid = 1'b0;
    t_idle("R10");
  endtask

  task automatic t_sweep();
    for (int oi = 0; oi < 3; oi++) begin
      for (int pv = 0; pv < 4; pv++) begin
        for (int c = 0; c < 64; c++) begin
          logic [2:0] oa;
          logic [5:0] cc;
          oa = (oi == 0) ? 3'd0 : (oi == 1) ? 3'd5 : 3'd4;
          cc = c[5:0];
          one($sformatf("R9 sweep opa=%0d priv=%0d ctl=%0h", oa, pv, cc), oa, pv[1:0], cc,
              model(oa, pv[1:0], cc[5], cc[4], cc[3], cc[2], cc[1], cc[0]));
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R10 run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; req_valid = 1'b0;
    drive(1'b0, 2'd0, 3'd0, 4'd0, 4'd0, 3'd0, 2'd0, 6'b0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nomatch();
    t_user();
    t_native_l1();
    t_native_hi();
    t_cross_l1();
    t_cross_hi();
    t_high_alias();
    t_timing();
    t_sweep();
    t_idle("R10 end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule